// File: doc/BRIEF.md
# Double-Buffered Four-Channel Converter Code Register

This block is the digital front end of a four-channel, 8-bit converter. A host drives an 8-bit data bus, a 2-bit channel select and two active-low strobes: a write strobe that loads one channel's staging register and a load strobe, shared by every channel, that moves staging contents into the output registers. The output registers alone set the four codes handed to the converters. Because each channel has two stages, new codes can be staged one channel at a time and then applied to all channels in the same cycle.

Both stages behave as level-transparent latches. The behaviour is built from clocked logic. Each strobe is brought into the clock domain through a synchroniser chain. On every cycle in which a synchronised strobe is low, the stages it controls are rewritten. If both strobes are held low, the data bus flows into the selected channel's output. A sticky flag reports when the load strobe is released too soon after the write strobe, so that the final bus value may not have reached the output.

Top module: `dac_dbuf_regs`

## Requirements
- R1: A synchronous active-high `rst` clears all four staging registers, all four output registers and `hold_err` to zero.
- R2: The channel select `addr` picks the staging register: 0 selects A, 1 selects B, 2 selects C and 3 selects D. In `codes`, A occupies bits 7:0, B bits 15:8, C bits 23:16 and D bits 31:24. A write changes only the selected staging register.
- R3: While the synchronised `wr_n` is low, the selected staging register takes `din` on every clock. After `wr_n` returns high, it keeps the last value taken.
- R4: `codes` comes only from the output registers. A write done while `ld_n` stays high leaves `codes` unchanged.
- R5: While the synchronised `ld_n` is low, every output register copies its staging register on each clock. When `ld_n` rises, all four outputs freeze together.
- R6: While both synchronised strobes are high, no register changes.
- R7: While both strobes are low, the selected channel's output follows `din`, two clocks behind the synchronised strobes.
- R8: Changes on `addr` and `din` while `wr_n` is high have no effect on any register.
- R9: `hold_err` is set when `ld_n` rises fewer than `HOLD_CYC` clocks after a rise of `wr_n` that happened while `ld_n` was low. A simultaneous rise also counts. The flag stays set until reset.
- R10: Each strobe passes through `SYNC` flip-flops before it acts. A strobe held low for `SYNC`+2 clocks completes its transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 8 | Data bus |
| addr | input | 2 | Channel select for the staging registers |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| ld_n | input | 1 | Load strobe shared by all channels, active low, asynchronous |
| codes | output | 32 | Four output codes, channel A in the low byte |
| hold_err | output | 1 | Sticky flag for a load released too early |

## Verification
The write and load stages can act in the same cycle. This happens when both strobes are held low together, and also when both are released on the same clock. The bench holds both strobes low and changes `din` twice, then checks that the selected byte of `codes` follows each value while the other bytes stay put. It then releases the write strobe well before the load strobe and expects the final value with `hold_err` clear. Finally it releases both strobes on the same edge and expects `hold_err` to be set.

// File: rtl/dac_dbuf_regs.sv
module dac_dbuf_regs #(
  parameter int W        = 8,
  parameter int CH       = 4,
  parameter int SYNC     = 2,
  parameter int HOLD_CYC = 3,
  localparam int AW      = $clog2(CH),
  localparam int CW      = $clog2(HOLD_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  din,
  input  logic [AW-1:0] addr,
  input  logic          wr_n,
  input  logic          ld_n,
  output logic [CH*W-1:0] codes,
  output logic          hold_err
);

  logic [SYNC-1:0] wr_sh, ld_sh;
  logic wr_q, ld_q;
  logic [CH*W-1:0] stage;
  logic [CW-1:0] cnt;

  wire wr_s    = wr_sh[SYNC-1];
  wire ld_s    = ld_sh[SYNC-1];
  wire wr_rise = wr_s & ~wr_q;
  wire ld_rise = ld_s & ~ld_q;
  wire arm     = wr_rise & ~ld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_sh <= '1;
      ld_sh <= '1;
      wr_q  <= 1'b1;
      ld_q  <= 1'b1;
    end else begin
      wr_sh <= {wr_sh[SYNC-2:0], wr_n};
      ld_sh <= {ld_sh[SYNC-2:0], ld_n};
      wr_q  <= wr_s;
      ld_q  <= ld_s;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage <= '0;
      codes <= '0;
    end else begin
      for (int k = 0; k < CH; k++) begin
        if (!wr_s && addr == AW'(k)) stage[k*W +: W] <= din;
        if (!ld_s) codes[k*W +: W] <= stage[k*W +: W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      hold_err <= 1'b0;
    end else begin
      if (arm)               cnt <= CW'(HOLD_CYC - 1);
      else if (ld_rise)      cnt <= '0;
      else if (cnt != '0)    cnt <= cnt - 1'b1;
      if (ld_rise && (arm || cnt != '0)) hold_err <= 1'b1;
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (codes == '0 && stage == '0 && !hold_err));                  // R1

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    (wr_s && ld_s) |=> ($stable(codes) && $stable(stage)));              // R6

  AST_WR_HIGH_HOLDS: assert property (@(posedge clk) disable iff (rst)
    wr_s |=> $stable(stage));                                            // R8

  AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (rst)
    !ld_s |=> codes == $past(stage));                                    // R5

  AST_LOAD_HIGH_HOLDS: assert property (@(posedge clk) disable iff (rst)
    ld_s |=> $stable(codes));                                            // R4

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    hold_err |=> hold_err);                                              // R9

  for (genvar g = 0; g < CH; g++) begin : g_chk
    AST_WR_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
      (!wr_s && addr == AW'(g)) |=> stage[g*W +: W] == $past(din));      // R3

    AST_OTHERS_KEEP: assert property (@(posedge clk) disable iff (rst)
      (!wr_s && addr != AW'(g)) |=> $stable(stage[g*W +: W]));           // R2
  end

endmodule

// File: tb/sim_dac_dbuf_regs.sv
module sim_dac_dbuf_regs;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] din = '0;
  logic [1:0] addr = '0;
  logic wr_n = 1'b1;
  logic ld_n = 1'b1;
  logic [31:0] codes;
  logic hold_err;
  int runs = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dac_dbuf_regs u0 (.clk(clk), .rst(rst), .din(din), .addr(addr),
                    .wr_n(wr_n), .ld_n(ld_n), .codes(codes), .hold_err(hold_err));

  // {load_op, addr, data, expected codes}
  localparam logic [42:0] VEC [9] = '{
    {1'b0, 2'd0, 8'h11, 32'h00000000},
    {1'b0, 2'd3, 8'h44, 32'h00000000},
    {1'b1, 2'd0, 8'h00, 32'h44000011},
    {1'b0, 2'd1, 8'h22, 32'h44000011},
    {1'b0, 2'd2, 8'h33, 32'h44000011},
    {1'b0, 2'd0, 8'h55, 32'h44000011},
    {1'b1, 2'd0, 8'h00, 32'h44332255},
    {1'b0, 2'd3, 8'h99, 32'h44332255},
    {1'b1, 2'd0, 8'h00, 32'h99332255}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_write(input logic [1:0] a, input logic [7:0] d);
    addr = a; din = d; wr_n = 1'b0;
    cyc(4);
    wr_n = 1'b1;
    cyc(4);
  endtask

  task automatic do_load();
    ld_n = 1'b0;
    cyc(4);
    ld_n = 1'b1;
    cyc(4);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    chk("R1 reset codes", codes, 32'h0);
    chk("R1 reset flag", {31'b0, hold_err}, 32'h0);

    for (int i = 0; i < 9; i++) begin
      if (VEC[i][42]) do_load();
      else do_write(VEC[i][41:40], VEC[i][39:32]);
      chk(VEC[i][42] ? "R5 R2 load vector" : "R4 R3 write vector", codes, VEC[i][31:0]);
    end

    // R8: address and data toggled with write high, then load
    addr = 2'd0; din = 8'hFF; cyc(3);
    addr = 2'd1; din = 8'hEE; cyc(3);
    do_load();
    chk("R8 bus ignored while write high", codes, 32'h99332255);

    // R6: idle with both strobes high
    din = 8'h5A; addr = 2'd2; cyc(10);
    chk("R6 idle stable", codes, 32'h99332255);

    // R5: load held low, outputs track writes
    ld_n = 1'b0; cyc(5);
    do_write(2'd1, 8'hAB);
    chk("R5 output tracks while load low", codes, 32'h9933AB55);
    ld_n = 1'b1; cyc(4);
    do_write(2'd1, 8'hCD);
    chk("R5 frozen after load rise", codes, 32'h9933AB55);
    do_write(2'd1, 8'hAB);

    // R7: both low, selected output follows the bus
    ld_n = 1'b0; addr = 2'd2; din = 8'h10; wr_n = 1'b0; cyc(5);
    chk("R7 follow first value", codes, 32'h9910AB55);
    din = 8'h20; cyc(3);
    chk("R7 follow second value", codes, 32'h9920AB55);
    wr_n = 1'b1; cyc(6);
    ld_n = 1'b1; cyc(4);
    chk("R7 final data latched", codes, 32'h9920AB55);
    chk("R9 no error with long hold", {31'b0, hold_err}, 32'h0);

    // R9: both strobes released on the same edge
    ld_n = 1'b0; addr = 2'd0; din = 8'h77; wr_n = 1'b0; cyc(5);
    wr_n = 1'b1; ld_n = 1'b1; cyc(5);
    chk("R9 simultaneous release flags", {31'b0, hold_err}, 32'h1);
    cyc(10);
    chk("R9 flag sticky", {31'b0, hold_err}, 32'h1);

    // R10: a strobe of SYNC+2 clocks completes
    addr = 2'd3; din = 8'h3C; wr_n = 1'b0; cyc(4); wr_n = 1'b1; cyc(3);
    ld_n = 1'b0; cyc(4); ld_n = 1'b1; cyc(3);
    chk("R10 short strobes transfer", codes[31:24], 32'h3C);

    rst = 1'b1; cyc(2); rst = 1'b0; cyc(1);
    chk("R1 reset clears codes", codes, 32'h0);
    chk("R1 reset clears flag", {31'b0, hold_err}, 32'h0);
    do_load();
    chk("R1 staging cleared", codes, 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule